// File: doc/BRIEF.md
# Received-Word Queue with Full Overwrite

This block buffers received serial-bus words that have already passed label filtering, one instance per receiver. The filter hands over a 32-bit word with a single-cycle valid strobe. The host empties the queue over a 16-bit bus. It reads each word as two halves, and a select input chooses which half a read returns. Three active-low flags report the queue state to the host as interrupt sources: data ready, half full and full.

The queue holds up to 32 words. Once it is full, it does not drop a new arrival. The new word replaces the most recently stored word, so the older contents survive until the host reads them. The head word leaves the queue only when the host reads its upper half. A read of the lower half can be repeated with no side effect.

Top module: `rxq_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, `data_ready_n`, `half_full_n` and `full_n` are all 1, `rd_data` is 0 and the queue is empty.
- R2: `data_ready_n` is 0 from the clock edge that stores a word. It returns to 1 only at the edge where an upper-half read removes the last stored word.
- R3: A read with `rd_sel`=0 loads bits [15:0] of the head word into `rd_data` at the read edge. The queue contents do not change, so repeating the read returns the same value.
- R4: A read with `rd_sel`=1 loads bits [31:16] of the head word into `rd_data` and removes that word from the queue.
- R5: Words leave the queue in the order they were stored.
- R6: `full_n` is 0 exactly while 32 words are stored.
- R7: `half_full_n` is 0 exactly while 16 or more words are stored. With 15 words it is 1.
- R8: A valid word that arrives while 32 words are stored, with no upper-half read in the same cycle, replaces the newest stored word. The count stays at 32, and the other 31 words and their order are unchanged.
- R9: If a word arrives in the same cycle as an upper-half read while 32 words are stored, the read takes the head word first. The new word is then appended at the tail and the count stays at 32.
- R10: A read of either half while the queue is empty loads 0 into `rd_data` and changes no stored state. A word written in that same cycle is still stored.
- R11: `rd_data` keeps its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_valid | input | 1 | One-cycle strobe: `wr_word` is an accepted received word |
| wr_word | input | 32 | Received word |
| rd_en | input | 1 | One-cycle host read strobe |
| rd_sel | input | 1 | Half select for the read: 0 = bits [15:0], 1 = bits [31:16] and remove the word |
| rd_data | output | 16 | Registered read result, updated at the read edge |
| data_ready_n | output | 1 | Low while at least one word is stored |
| half_full_n | output | 1 | Low while 16 or more words are stored |
| full_n | output | 1 | Low while 32 words are stored |

## Verification
A short table of reads and writes from the empty state exercises several patterns. Repeated lower-half reads tell a non-consuming read from a consuming one. Interleaved stores and reads check ordering. A read and a write in the same cycle on an empty queue shows that the empty read returns zero while the write still lands. Directed filling then steps through 15 and 16 words to place the half-full threshold, and through 32 words for the full flag. A plain overwrite and a simultaneous read-plus-write at 32 words are distinguished by draining the whole queue and comparing every half against the order the requirements predict.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // What the write side does with an arriving word in a given cycle
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_action_e;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic                       rd_en,
  input  logic                       rd_sel,
  output logic                       store_en,
  output logic [$clog2(DEPTH)-1:0]   store_addr,
  output logic [$clog2(DEPTH)-1:0]   head_addr,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       is_empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] level_q, level_d;
  logic          is_full;
  logic          pop;
  logic          push;
  wr_action_e    action;

  assign is_empty = (level_q == '0);
  assign is_full  = (level_q == CW'(DEPTH));

  // Only an upper-half read on a non-empty queue removes the head word
  assign pop = rd_en & rd_sel & ~is_empty;

  // A read in the same cycle frees a slot before the write is placed
  always_comb begin
    action = WR_NONE;
    if (wr_valid) begin
      if (!is_full || pop) action = WR_APPEND;
      else                 action = WR_REPLACE;
    end
  end

  assign push = (action == WR_APPEND);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push) wr_ptr_d = wr_ptr_q + AW'(1);
    if (pop)  rd_ptr_d = rd_ptr_q + AW'(1);
    if (push && !pop)      level_d = level_q + CW'(1);
    else if (!push && pop) level_d = level_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  assign store_en   = (action != WR_NONE);
  assign store_addr = (action == WR_REPLACE) ? (wr_ptr_q - AW'(1)) : wr_ptr_q;
  assign head_addr  = rd_ptr_q;
  assign level      = level_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      store_en,
  input  logic [$clog2(DEPTH)-1:0]  store_addr,
  input  logic [WORD_W-1:0]         store_word,
  input  logic [$clog2(DEPTH)-1:0]  head_addr,
  output logic [WORD_W-1:0]         head_word
);

  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] slot_q [DEPTH];

  // One enabled register per slot; contents need no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = store_en && (store_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= store_word;
    end
  end

  assign head_word = slot_q[head_addr];

endmodule

// File: rtl/rxq_readport.sv
module rxq_readport #(
  parameter int HALF_W = 16,
  parameter int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              is_empty,
  input  logic [WORD_W-1:0] head_word,
  output logic [HALF_W-1:0] rd_data
);

  logic [HALF_W-1:0] half_sel;
  logic [HALF_W-1:0] data_d;
  logic [HALF_W-1:0] data_q;

  assign half_sel = rd_sel ? head_word[WORD_W-1:HALF_W] : head_word[HALF_W-1:0];

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = is_empty ? '0 : half_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 32
) (
  input  logic [$clog2(DEPTH):0] level,
  output logic                   data_ready_n,
  output logic                   half_full_n,
  output logic                   full_n
);

  localparam int CW        = $clog2(DEPTH) + 1;
  localparam int HALF_MARK = DEPTH / 2;

  assign data_ready_n = (level == '0);
  assign half_full_n  = !(level >= CW'(HALF_MARK));
  assign full_n       = !(level == CW'(DEPTH));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 16,
  parameter int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [HALF_W-1:0] rd_data,
  output logic              data_ready_n,
  output logic              half_full_n,
  output logic              full_n
);

  localparam int AW = $clog2(DEPTH);

  logic              store_en;
  logic [AW-1:0]     store_addr;
  logic [AW-1:0]     head_addr;
  logic [AW:0]       level;
  logic              is_empty;
  logic [WORD_W-1:0] head_word;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .store_en   (store_en),
    .store_addr (store_addr),
    .head_addr  (head_addr),
    .level      (level),
    .is_empty   (is_empty)
  );

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .store_en   (store_en),
    .store_addr (store_addr),
    .store_word (wr_word),
    .head_addr  (head_addr),
    .head_word  (head_word)
  );

  rxq_readport #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_rdp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .is_empty  (is_empty),
    .head_word (head_word),
    .rd_data   (rd_data)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .level        (level),
    .data_ready_n (data_ready_n),
    .half_full_n  (half_full_n),
    .full_n       (full_n)
  );

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_en,
  input logic              rd_sel,
  input logic [HALF_W-1:0] rd_data,
  input logic              data_ready_n,
  input logic              half_full_n,
  input logic              full_n
);

  // R6/R7: full implies half full
  p_full_has_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_full_n);

  // R7: half full implies data ready
  p_half_has_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !half_full_n |-> !data_ready_n);

  // R2: the queue only empties through an upper-half read
  p_empty_by_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready_n) |-> $past(rd_en && rd_sel));

  // R3: a lower-half read never drains the queue
  p_low_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !data_ready_n) |=> !data_ready_n);

  // R8: a lone arrival at full leaves the queue full
  p_overwrite_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid && !(rd_en && rd_sel)) |=> !full_n);

  // R9: read plus arrival at full leaves the queue full
  p_swap_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid && rd_en && rd_sel) |=> !full_n);

  // R10: empty reads return zero
  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_ready_n) |=> (rd_data == '0));

  // R11: output holds without a read
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind rxq_fifo rxq_fifo_chk u_rxq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .rd_en        (rd_en),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .data_ready_n (data_ready_n),
  .half_full_n  (half_full_n),
  .full_n       (full_n)
);

// File: tb/rxq_fifo_tb_top.sv
module rxq_fifo_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [31:0] wr_word;
  logic        rd_en;
  logic        rd_sel;
  logic [15:0] rd_data;
  logic        data_ready_n;
  logic        half_full_n;
  logic        full_n;

  int n_checks;
  int n_fails;
  int cycles;

  rxq_fifo dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_word      (wr_word),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .data_ready_n (data_ready_n),
    .half_full_n  (half_full_n),
    .full_n       (full_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        sel;
    logic [31:0] wdata;
    logic [15:0] exp_data;
    logic [2:0]  exp_flags;  // {data_ready_n, half_full_n, full_n}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'h0000, 3'b111, 4'd10}, // R10 low read, empty
    '{1'b0, 1'b1, 1'b1, 32'h0,         16'h0000, 3'b111, 4'd10}, // R10 high read, empty
    '{1'b1, 1'b0, 1'b0, 32'hA1B2_C3D4, 16'h0000, 3'b011, 4'd2 }, // R2 ready after store
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'hC3D4, 3'b011, 4'd3 }, // R3 low half
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'hC3D4, 3'b011, 4'd3 }, // R3 repeated, no consume
    '{1'b1, 1'b0, 1'b0, 32'h1111_2222, 16'hC3D4, 3'b011, 4'd11}, // R11 hold on write
    '{1'b0, 1'b1, 1'b1, 32'h0,         16'hA1B2, 3'b011, 4'd4 }, // R4 high half, one left
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'h2222, 3'b011, 4'd5 }, // R5 next word
    '{1'b0, 1'b1, 1'b1, 32'h0,         16'h1111, 3'b111, 4'd2 }, // R2 ready clears
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'h0000, 3'b111, 4'd10}, // R10 empty again
    '{1'b1, 1'b1, 1'b1, 32'h5A5A_0F0F, 16'h0000, 3'b011, 4'd10}, // R10 empty read with write
    '{1'b0, 1'b1, 1'b0, 32'h0,         16'h0F0F, 3'b011, 4'd10}, // R10 write survived
    '{1'b0, 1'b1, 1'b1, 32'h0,         16'h5A5A, 3'b111, 4'd4 }  // R4 drain
  };

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {data_ready_n, half_full_n, full_n};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s flags: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic w, input logic [31:0] d, input logic r, input logic s);
    wr_valid = w;
    wr_word  = d;
    rd_en    = r;
    rd_sel   = s;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    rd_en    = 1'b0;
    rd_sel   = 1'b0;
  endtask

  function automatic logic [31:0] fill_word(input int i);
    return {16'(16'hB000 + i), 16'(16'h0100 + i)};
  endfunction

  function automatic logic [2:0] flags_for(input int lvl);
    return {lvl == 0, !(lvl >= 16), !(lvl == 32)};
  endfunction

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] exp_word;
    n_checks = 0;
    n_fails  = 0;
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    wr_word  = '0;
    rd_en    = 1'b0;
    rd_sel   = 1'b0;
    repeat (3) @(negedge clk);
    check_flags("R1 in reset", 3'b111);
    check16("R1 in reset data", rd_data, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R1 after reset", 3'b111);
    check16("R1 after reset data", rd_data, 16'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      cyc(VECS[v].wr, VECS[v].wdata, VECS[v].rd, VECS[v].sel);
      check16($sformatf("R%0d vec %0d", VECS[v].req, v), rd_data, VECS[v].exp_data);
      check_flags($sformatf("R%0d vec %0d", VECS[v].req, v), VECS[v].exp_flags);
    end

    // R7 threshold: 15 then 16 words
    for (int i = 0; i < 15; i++) cyc(1'b1, fill_word(i), 1'b0, 1'b0);
    check_flags("R7 at 15 words", 3'b011);
    cyc(1'b1, fill_word(15), 1'b0, 1'b0);
    check_flags("R7 at 16 words", 3'b001);
    for (int i = 16; i < 31; i++) cyc(1'b1, fill_word(i), 1'b0, 1'b0);
    check_flags("R6 at 31 words", 3'b001);
    cyc(1'b1, fill_word(31), 1'b0, 1'b0);
    check_flags("R6 at 32 words", 3'b000);

    // R8 overwrite of the newest slot
    cyc(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    check_flags("R8 still full", 3'b000);

    // R9 read and arrival together at full
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    check16("R9 head low before swap", rd_data, 16'h0100);
    cyc(1'b1, 32'h7E57_CAFE, 1'b1, 1'b1);
    check16("R9 head high at swap", rd_data, 16'hB000);
    check_flags("R9 still full", 3'b000);

    // Drain: words 1..30, then the overwrite, then the swapped-in word
    for (int k = 0; k < 32; k++) begin
      if (k < 30)       exp_word = fill_word(k + 1);
      else if (k == 30) exp_word = 32'hDEAD_BEEF;
      else              exp_word = 32'h7E57_CAFE;
      cyc(1'b0, 32'h0, 1'b1, 1'b0);
      check16($sformatf("R5 R8 R9 drain %0d low", k), rd_data, exp_word[15:0]);
      cyc(1'b0, 32'h0, 1'b1, 1'b1);
      check16($sformatf("R5 R8 R9 drain %0d high", k), rd_data, exp_word[31:16]);
      check_flags($sformatf("R6 R7 drain %0d", k), flags_for(31 - k));
    end

    // R10 empty read leaves pointers alone
    cyc(1'b0, 32'h0, 1'b1, 1'b1);
    check16("R10 empty after drain", rd_data, 16'h0);
    cyc(1'b1, 32'h1357_2468, 1'b0, 1'b0);
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    check16("R10 pointer intact", rd_data, 16'h2468);

    // R1 reset in mid-run clears state
    cyc(1'b1, 32'h9999_8888, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check_flags("R1 mid-run reset", 3'b111);
    check16("R1 mid-run reset data", rd_data, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    check16("R1 queue emptied by reset", rd_data, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule